// File: doc/BRIEF.md
# Timer and Keyed Watchdog Unit

This block holds two general-purpose down-counting timers, a free-running 32-bit timestamp counter and a watchdog counter. All of them run on the bus clock and sit behind a simple word-addressed register port. Each timer has a reload register. The two low bits of that register are control bits: one enables the timer and one selects single-shot or periodic operation. The remaining bits give the reload value. The counter register can also be written directly.

The watchdog has its own count, a control register and a key register. The count and control registers accept writes only while the key register holds the unlock value. The control register has three independent bits: one lets the count run, one lets an expiry raise an interrupt flag, and one lets an expiry request a warm reset. Every event source sets its own bit in a shared status register. Software clears a status bit by writing a 1 to it. The status register is driven out of the block as interrupt flags, and a warm-reset expiry also drives a single-cycle request pulse to the reset logic.

Top module: `tmr_wdog_unit`

## Requirements
- R1: After reset, every register reads zero, `evt_status` and `warm_rst_req` are low, and the watchdog is locked.
- R2: Registers sit at byte offsets 0x00 timestamp, 0x04/0x08 timer 0 count/reload, 0x0C/0x10 timer 1 count/reload, 0x14 watchdog count, 0x18 watchdog control, 0x1C key, 0x20 status. Reads return the current value. Unmapped offsets read zero and ignore writes.
- R3: The timestamp increments by one every cycle unless it is written, in which case it loads the written value. Stepping from 0xFFFFFFFF to 0 sets status bit 2.
- R4: A timer whose reload bit 0 is set counts down by one each cycle. When its count is zero it sets its status bit (timer 0 bit 0, timer 1 bit 1). With reload bit 1 clear, it then loads `reload & 0xFFFFFFFC`.
- R5: In single-shot mode (reload bit 1 set), a timer that reaches zero sets its status bit, clears reload bit 0 and keeps its count at zero.
- R6: In a cycle where a timer's count or reload register is written, that timer does not step. A written count shows up unchanged on the next read.
- R7: Writes to the watchdog count and control registers take effect only while the key register equals 0x0000482E. Writing any other key value locks them again. The key register reads back what was written.
- R8: While control bit 2 is set, the watchdog count decrements. At zero it clears bit 2. If bit 1 is set it sets status bit 3. If bit 0 is set it sets status bit 4 and pulses `warm_rst_req` for exactly one cycle, the same cycle in which bit 4 appears. A cycle with an effective count or control write does not step the watchdog.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a new event arrives in the same cycle as the clear, the bit stays set.
- R10: `evt_status` always equals the status register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_status | output | 5 | Status flags: timer0, timer1, timestamp wrap, watchdog interrupt, warm reset |
| warm_rst_req | output | 1 | Single-cycle warm-reset request |

## Verification
A status bit can receive a write-1 clear in the same cycle that its source fires. The bench provokes this by loading the timestamp two steps below the wrap point and then timing a status clear onto the wrap edge; the wrap flag must survive. Random traffic also writes to counters in the same cycle that they expire. A cycle-level reference model in the bench judges every one of these collisions, comparing the read data, the flags and the reset pulse each cycle.

// File: rtl/tmr_wdog_pkg.sv
`timescale 1ns/1ps
package tmr_wdog_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned NUM_GPT = 2;
    localparam int unsigned ST_W    = 5;
    localparam logic [DATA_W-1:0] WD_UNLOCK = 32'h0000_482E;

    // word index of each register (byte offset / 4)
    localparam int unsigned IDX_STAMP  = 0;
    localparam int unsigned IDX_GPT0   = 1;  // timer i count at 1+2i, reload at 2+2i
    localparam int unsigned IDX_WD_CNT = 5;
    localparam int unsigned IDX_WD_CTL = 6;
    localparam int unsigned IDX_WD_KEY = 7;
    localparam int unsigned IDX_STATUS = 8;

    // status bit positions
    localparam int unsigned ST_STAMP = 2;
    localparam int unsigned ST_WDIRQ = 3;
    localparam int unsigned ST_WRST  = 4;
endpackage

// File: rtl/tmr_gp_timer.sv
`timescale 1ns/1ps
module tmr_gp_timer #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_wr,
    input  logic         rld_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] rld_o,
    output logic         fire_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
    } gpt_state_t;

    gpt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        if (st_q.rld[0] && !cnt_wr && !rld_wr) begin
            if (st_q.cnt == '0) begin
                fire_o = 1'b1;
                if (st_q.rld[1]) st_d.rld[0] = 1'b0;
                else             st_d.cnt    = {st_q.rld[W-1:2], 2'b00};
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (cnt_wr) st_d.cnt = wdata;
        if (rld_wr) st_d.rld = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign rld_o = st_q.rld;
endmodule

// File: rtl/tmr_wdog_core.sv
`timescale 1ns/1ps
module tmr_wdog_core
    import tmr_wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr,
    input  logic              ctl_wr,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_o,
    output logic [2:0]        ctl_o,
    output logic [DATA_W-1:0] key_o,
    output logic              unlocked_o,
    output logic              irq_evt_o,
    output logic              rst_evt_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [2:0]        ctl;   // [0] reset en, [1] irq en, [2] run
        logic [DATA_W-1:0] key;
    } wd_state_t;

    wd_state_t st_d, st_q;
    logic      cnt_ok, ctl_ok;
    logic      unused_hi;

    assign unused_hi  = ^wdata[DATA_W-1:3];
    assign unlocked_o = (st_q.key == WD_UNLOCK);
    assign cnt_ok     = cnt_wr && unlocked_o;
    assign ctl_ok     = ctl_wr && unlocked_o;

    always_comb begin
        st_d      = st_q;
        irq_evt_o = 1'b0;
        rst_evt_o = 1'b0;
        if (st_q.ctl[2] && !cnt_ok && !ctl_ok) begin
            if (st_q.cnt == '0) begin
                irq_evt_o    = st_q.ctl[1];
                rst_evt_o    = st_q.ctl[0];
                st_d.ctl[2]  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (cnt_ok) st_d.cnt = wdata;
        if (ctl_ok) st_d.ctl = wdata[2:0];
        if (key_wr) st_d.key = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ctl_o = st_q.ctl;
    assign key_o = st_q.key;
endmodule

// File: rtl/tmr_wdog_unit.sv
`timescale 1ns/1ps
module tmr_wdog_unit
    import tmr_wdog_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [4:0]        evt_status,
    output logic              warm_rst_req
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] ts;
        logic [ST_W-1:0]   status;
        logic              warm;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [IDX_W-1:0]  idx;
    logic              unused_lsb;
    logic [DATA_W-1:0] tm_cnt [NUM_GPT];
    logic [DATA_W-1:0] tm_rld [NUM_GPT];
    logic [NUM_GPT-1:0] tm_fire;
    logic [DATA_W-1:0] wd_cnt, wd_key, ts_now;
    logic [2:0]        wd_ctl;
    logic              wd_unlocked, wd_irq_evt, wd_rst_evt;
    logic [ST_W-1:0]   evt;

    assign idx        = reg_addr[ADDR_W-1:2];
    assign unused_lsb = ^reg_addr[1:0];
    assign ts_now     = st_q.ts;

    for (genvar g = 0; g < NUM_GPT; g++) begin : g_gpt
        tmr_gp_timer #(.W(DATA_W)) i_gpt (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_wr (reg_we && idx == IDX_W'(IDX_GPT0 + 2*g)),
            .rld_wr (reg_we && idx == IDX_W'(IDX_GPT0 + 2*g + 1)),
            .wdata  (reg_wdata),
            .cnt_o  (tm_cnt[g]),
            .rld_o  (tm_rld[g]),
            .fire_o (tm_fire[g])
        );
    end

    tmr_wdog_core i_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_wr     (reg_we && idx == IDX_W'(IDX_WD_CNT)),
        .ctl_wr     (reg_we && idx == IDX_W'(IDX_WD_CTL)),
        .key_wr     (reg_we && idx == IDX_W'(IDX_WD_KEY)),
        .wdata      (reg_wdata),
        .cnt_o      (wd_cnt),
        .ctl_o      (wd_ctl),
        .key_o      (wd_key),
        .unlocked_o (wd_unlocked),
        .irq_evt_o  (wd_irq_evt),
        .rst_evt_o  (wd_rst_evt)
    );

    always_comb begin
        st_d = st_q;
        evt  = '0;
        evt[NUM_GPT-1:0] = tm_fire;
        evt[ST_WDIRQ]    = wd_irq_evt;
        evt[ST_WRST]     = wd_rst_evt;
        if (reg_we && idx == IDX_W'(IDX_STAMP)) begin
            st_d.ts = reg_wdata;
        end else begin
            evt[ST_STAMP] = &st_q.ts;
            st_d.ts       = st_q.ts + 1'b1;
        end
        if (reg_we && idx == IDX_W'(IDX_STATUS))
            st_d.status = st_q.status & ~reg_wdata[ST_W-1:0];
        st_d.status = st_d.status | evt;
        st_d.warm   = wd_rst_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (idx == IDX_W'(IDX_STAMP))  reg_rdata = st_q.ts;
        if (idx == IDX_W'(IDX_WD_CNT)) reg_rdata = wd_cnt;
        if (idx == IDX_W'(IDX_WD_CTL)) reg_rdata = {29'd0, wd_ctl};
        if (idx == IDX_W'(IDX_WD_KEY)) reg_rdata = wd_key;
        if (idx == IDX_W'(IDX_STATUS)) reg_rdata = {27'd0, st_q.status};
        for (int i = 0; i < NUM_GPT; i++) begin
            if (idx == IDX_W'(IDX_GPT0 + 2*i))     reg_rdata = tm_cnt[i];
            if (idx == IDX_W'(IDX_GPT0 + 2*i + 1)) reg_rdata = tm_rld[i];
        end
    end

    assign evt_status   = st_q.status;
    assign warm_rst_req = st_q.warm;
endmodule

// File: rtl/tmr_wdog_checker.sv
`timescale 1ns/1ps
module tmr_wdog_checker #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [4:0]        evt_status,
    input logic              warm_rst_req,
    input logic              wd_unlocked,
    input logic [31:0]       wd_cnt,
    input logic              wd_run,
    input logic [31:0]       ts
);
    localparam int unsigned IDX_W = ADDR_W - 2;
    logic [IDX_W-1:0] idx;
    assign idx = reg_addr[ADDR_W-1:2];

    // R8: the reset request lasts a single cycle
    assert_warm_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |=> !warm_rst_req);

    // R8: the request comes with the warm-reset status flag
    assert_warm_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |-> evt_status[4]);

    // R3: the timestamp steps by one unless written
    assert_ts_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && idx == IDX_W'(0)) |=> ts == $past(ts) + 32'd1);

    // R7: a locked count write leaves a stopped watchdog unchanged
    assert_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && idx == IDX_W'(5) && !wd_unlocked && !wd_run) |=> $stable(wd_cnt));

    // R9: a set flag survives every cycle that does not clear it
    for (genvar b = 0; b < 5; b++) begin : g_sticky
        assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_status[b] && !(reg_we && idx == IDX_W'(8) && reg_wdata[b])) |=> evt_status[b]);
    end
endmodule

bind tmr_wdog_unit tmr_wdog_checker #(.ADDR_W(ADDR_W)) i_tmr_wdog_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .evt_status   (evt_status),
    .warm_rst_req (warm_rst_req),
    .wd_unlocked  (wd_unlocked),
    .wd_cnt       (wd_cnt),
    .wd_run       (wd_ctl[2]),
    .ts           (ts_now)
);

// File: tb/test_tmr_wdog_unit.sv
`timescale 1ns/1ps
module test_tmr_wdog_unit;
    logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    wire  [31:0] reg_rdata;
    wire  [4:0]  evt_status;
    wire         warm_rst_req;
    int checks = 0, fails = 0;
    bit cmp_on = 1'b0;

    tmr_wdog_unit i_tmr_wdog_unit (.clk(clk), .rst_n(rst_n), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_status(evt_status), .warm_rst_req(warm_rst_req));

    always #10 clk = ~clk;

    // reference model state
    logic [31:0] m_ts, m_cnt [2], m_rld [2], m_wcnt, m_key;
    logic [2:0]  m_wctl;
    logic [4:0]  m_st, ev;
    logic        m_warm, cw, rw, unl, wcw, wtw;
    logic [3:0]  widx;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(logic [5:0] a);
        case (a[5:2])
            4'd0: return m_ts;
            4'd1: return m_cnt[0];
            4'd2: return m_rld[0];
            4'd3: return m_cnt[1];
            4'd4: return m_rld[1];
            4'd5: return m_wcnt;
            4'd6: return {29'd0, m_wctl};
            4'd7: return m_key;
            4'd8: return {27'd0, m_st};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(logic [5:0] a);
        case (a[5:2])
            4'd0: return "R3";
            4'd1, 4'd2, 4'd3, 4'd4: return "R4";
            4'd5, 4'd6, 4'd7: return "R7";
            4'd8: return "R9";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ts = '0; m_cnt[0] = '0; m_cnt[1] = '0; m_rld[0] = '0; m_rld[1] = '0;
            m_wcnt = '0; m_key = '0; m_wctl = '0; m_st = '0; m_warm = 1'b0;
        end else begin
            ev = '0;
            widx = reg_addr[5:2];
            if (reg_we && widx == 4'd0) m_ts = reg_wdata;
            else begin
                if (m_ts == 32'hFFFF_FFFF) ev[2] = 1'b1;
                m_ts = m_ts + 32'd1;
            end
            for (int i = 0; i < 2; i++) begin
                cw = reg_we && widx == 4'(1 + 2*i);
                rw = reg_we && widx == 4'(2 + 2*i);
                if (m_rld[i][0] && !cw && !rw) begin
                    if (m_cnt[i] == 32'd0) begin
                        ev[i] = 1'b1;
                        if (m_rld[i][1]) m_rld[i][0] = 1'b0;
                        else m_cnt[i] = m_rld[i] & 32'hFFFF_FFFC;
                    end else m_cnt[i] = m_cnt[i] - 32'd1;
                end
                if (cw) m_cnt[i] = reg_wdata;
                if (rw) m_rld[i] = reg_wdata;
            end
            unl = (m_key == 32'h0000_482E);
            wcw = reg_we && widx == 4'd5 && unl;
            wtw = reg_we && widx == 4'd6 && unl;
            m_warm = 1'b0;
            if (m_wctl[2] && !wcw && !wtw) begin
                if (m_wcnt == 32'd0) begin
                    if (m_wctl[1]) ev[3] = 1'b1;
                    if (m_wctl[0]) begin ev[4] = 1'b1; m_warm = 1'b1; end
                    m_wctl[2] = 1'b0;
                end else m_wcnt = m_wcnt - 32'd1;
            end
            if (wcw) m_wcnt = reg_wdata;
            if (wtw) m_wctl = reg_wdata[2:0];
            if (reg_we && widx == 4'd7) m_key = reg_wdata;
            if (reg_we && widx == 4'd8) m_st = m_st & ~reg_wdata[4:0];
            m_st = m_st | ev;
        end
    end

    // per-cycle comparison against the model, before inputs change
    always @(negedge clk) if (cmp_on) begin
        chk(req_of(reg_addr), reg_rdata, mread(reg_addr));
        chk("R10", {27'd0, evt_status}, {27'd0, m_st});
        chk("R8", {31'd0, warm_rst_req}, {31'd0, m_warm});
    end

    task automatic cyc(logic we, logic [5:0] a, logic [31:0] d);
        @(negedge clk); #1;
        reg_we = we; reg_addr = a; reg_wdata = d;
    endtask

    task automatic peek(logic [5:0] a, output logic [31:0] v);
        @(negedge clk); #1;
        reg_we = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 act=running exp=finished");
        summary();
    end

    initial begin
        logic [31:0] v, v2;
        int n;
        void'($urandom(32'd7341));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int a = 1; a <= 8; a++) begin
            peek(6'(a * 4), v);
            chk("R1", v, 32'd0);
        end
        chk("R1", {27'd0, evt_status, warm_rst_req}, 32'd0);
        cmp_on = 1'b1;
        // R3 consecutive reads step by one
        peek(6'h00, v); peek(6'h00, v2);
        chk("R3", v2 - v, 32'd1);
        // R7 locked write ignored, unlock, relock
        cyc(1, 6'h14, 32'h55); peek(6'h14, v); chk("R7", v, 32'd0);
        cyc(1, 6'h1C, 32'h482E); cyc(1, 6'h14, 32'h55); peek(6'h14, v); chk("R7", v, 32'h55);
        cyc(1, 6'h1C, 32'h1234); cyc(1, 6'h14, 32'h99); peek(6'h14, v); chk("R7", v, 32'h55);
        peek(6'h1C, v); chk("R7", v, 32'h1234);
        // R2 unmapped offset and reload readback
        cyc(1, 6'h3C, 32'hDEAD_BEEF); peek(6'h3C, v); chk("R2", v, 32'd0);
        cyc(1, 6'h10, 32'hFFFF_FFF0); peek(6'h10, v); chk("R2", v, 32'hFFFF_FFF0);
        // R5 single-shot timer 0
        cyc(1, 6'h04, 32'd4); cyc(1, 6'h08, 32'h0000_0103);
        repeat (12) cyc(0, 6'h00, 0);
        peek(6'h04, v); chk("R5", v, 32'd0);
        peek(6'h08, v); chk("R5", v, 32'h0000_0102);
        chk("R5", {31'd0, evt_status[0]}, 32'd1);
        // R4 periodic timer 1
        cyc(1, 6'h0C, 32'd2); cyc(1, 6'h10, 32'h0000_0011);
        repeat (30) cyc(0, 6'h00, 0);
        peek(6'h0C, v); chk("R4", {31'd0, v <= 32'h10}, 32'd1);
        chk("R4", {31'd0, evt_status[1]}, 32'd1);
        cyc(1, 6'h10, 32'd0);
        // R9 clear one flag, others kept
        cyc(1, 6'h20, 32'h2); peek(6'h20, v); chk("R9", v & 32'h3, 32'h1);
        // R9 clear coinciding with timestamp wrap
        cyc(1, 6'h00, 32'hFFFF_FFFE); cyc(0, 6'h00, 0); cyc(1, 6'h20, 32'h4);
        peek(6'h20, v); chk("R9", v & 32'h4, 32'h4);
        cyc(1, 6'h20, 32'h4); peek(6'h20, v); chk("R9", v & 32'h4, 32'h0);
        // R8 watchdog expiry with interrupt and reset
        cyc(1, 6'h1C, 32'h482E); cyc(1, 6'h14, 32'd3); cyc(1, 6'h18, 32'h7);
        cyc(0, 6'h00, 0);
        n = 0;
        repeat (20) begin @(negedge clk); #2; if (warm_rst_req) n++; end
        chk("R8", n, 1);
        peek(6'h18, v); chk("R8", v, 32'h3);
        chk("R8", {30'd0, evt_status[4:3]}, 32'h3);
        // R6 count write while running
        cyc(1, 6'h08, 32'h0000_0041); cyc(1, 6'h04, 32'h1000);
        peek(6'h04, v); chk("R6", v, 32'h1000);
        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic [3:0] ix;
            logic [31:0] d;
            ix = 4'($urandom_range(0, 11));
            case (ix)
                4'd0: d = ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFF0 + $urandom_range(0, 15) : $urandom;
                4'd1, 4'd3, 4'd5: d = $urandom_range(0, 20);
                4'd2, 4'd4: d = ($urandom_range(0, 40) << 2) | $urandom_range(0, 3);
                4'd6: d = $urandom_range(0, 7);
                4'd7: d = ($urandom_range(0, 1) != 0) ? 32'h482E : $urandom_range(0, 65535);
                4'd8: d = $urandom_range(0, 31);
                default: d = $urandom;
            endcase
            cyc($urandom_range(0, 3) == 0, {ix, 2'($urandom_range(0, 3))}, d);
        end
        cyc(0, 6'h00, 0);
        @(negedge clk);
        summary();
    end
endmodule